// File: doc/BRIEF.md
# Host Clock Output Divider

This block derives a free-running clock for an attached host controller from the reference oscillator. A 3-bit code picks one of eight output rates. Five of them are power-of-two divides of the 16 MHz reference (16 MHz down to 1 MHz). The other three are slow rates for low-power operation: 62.5 kHz, about 32.786 kHz and about 16.393 kHz. Every rate has a 50% duty cycle, including the undivided 16 MHz setting. For that reason the block runs on a core clock at twice the reference frequency, and each output half-period is a whole number of core cycles.

The output is gated by the current power mode. In Idle it always runs. In Doze it runs only when the Doze output enable is set and the selected rate is 1 MHz or slower. In Hibernate and Off it stays low. A change of rate or of permission is applied only where one output period ends and the next would begin, so the output never shows a shortened pulse. Once stopped, the output stays low. It starts again with a full high phase on the first core edge at which the mode allows it.

Top module: `hclk_div`

## Requirements
- R1: While `rst_n` is low, `host_clk` is low, and asserting `rst_n` drives it low at once.
- R2: Rate codes 0, 1, 2, 3, 4, 5, 6 and 7 give half-periods of 1, 2, 4, 8, 16, 256, 488 and 976 core cycles, which are divides of 1, 2, 4, 8, 16, 256, 488 and 976 of the reference.
- R3: At every rate the high phase and the low phase of a period each last exactly the half-period of that rate.
- R4: A change on `rate_sel` during a period leaves that period unchanged. The new rate starts with the next period.
- R5: With `pwr_mode` = 0 (Idle) the output runs at every rate code, whatever the value of `doze_clk_en`.
- R6: With `pwr_mode` = 1 (Doze) a period is started only if `doze_clk_en` is 1 and the rate code is 4 or higher (1 MHz or slower). Otherwise the output stays low.
- R7: With `pwr_mode` = 2 (Hibernate) or 3 (Off) no period is started and the output stays low.
- R8: Losing permission during a period lets that period finish in full, then holds the output low. When permission returns, the output goes high on the next core edge and begins a full period.
- R9: The first period after reset uses rate code 6 (about 32.786 kHz), whatever the value of `rate_sel`. Later periods follow `rate_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref2x_clk | input | 1 | Core clock at twice the reference frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Output rate code (see R2) |
| doze_clk_en | input | 1 | Allows the output in Doze for slow rates |
| pwr_mode | input | 2 | 0 Idle, 1 Doze, 2 Hibernate, 3 Off |
| host_clk | output | 1 | Divided host clock |

## Verification
The bench builds the block with its default divides of 256, 488 and 976 for the slow rates, with rate code 6 as the reset rate, and with code 4 as the fastest rate allowed in Doze. Even the slowest period is under 2,000 core cycles, so the bench can measure every rate in full at its true length. It can also move the rate and the power mode in the middle of the longest high phase to show that the period still completes. The Doze boundary falls between codes 3 and 4. Both sides of it are therefore reachable with short periods.

// File: rtl/hclk_div_pkg.sv
package hclk_div_pkg;

  typedef enum logic [1:0] {
    PM_IDLE      = 2'd0,
    PM_DOZE      = 2'd1,
    PM_HIBERNATE = 2'd2,
    PM_OFF       = 2'd3
  } pwr_mode_e;

  // rate codes up to this value are plain powers of two
  localparam logic [2:0] POW2_LAST = 3'd4;

  // half-period in core cycles for a rate code
  function automatic int unsigned ratio_of(input logic [2:0] sel,
                                           input int unsigned d_lo,
                                           input int unsigned d_mid,
                                           input int unsigned d_hi);
    int unsigned r;
    if (sel <= POW2_LAST)  r = 32'd1 << sel;
    else if (sel == 3'd5)  r = d_lo;
    else if (sel == 3'd6)  r = d_mid;
    else                   r = d_hi;
    return r;
  endfunction

  // may a new period start under this mode and rate?
  function automatic logic out_permitted(input pwr_mode_e m,
                                         input logic en,
                                         input logic [2:0] sel,
                                         input logic [2:0] min_sel);
    logic ok;
    case (m)
      PM_IDLE: ok = 1'b1;
      PM_DOZE: ok = en && (sel >= min_sel);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/hclk_rate_pick.sv
module hclk_rate_pick
  import hclk_div_pkg::*;
#(
  parameter logic [2:0] DEFAULT_SEL  = 3'd6,
  parameter logic [2:0] DOZE_MIN_SEL = 3'd4
) (
  input  logic       fresh_i,
  input  logic [2:0] rate_sel_i,
  input  logic [1:0] mode_i,
  input  logic       doze_en_i,
  output logic [2:0] cand_sel_o,
  output logic       cand_ok_o
);

  always_comb begin
    cand_sel_o = fresh_i ? DEFAULT_SEL : rate_sel_i;
    cand_ok_o  = out_permitted(pwr_mode_e'(mode_i), doze_en_i, cand_sel_o, DOZE_MIN_SEL);
  end

endmodule

// File: rtl/hclk_rate_reg.sv
module hclk_rate_reg #(
  parameter logic [2:0] DEFAULT_SEL = 3'd6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [2:0] cand_sel_i,
  output logic [2:0] active_sel_o,
  output logic       fresh_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_sel_o <= DEFAULT_SEL;
      fresh_o      <= 1'b1;
    end else if (load_i) begin
      active_sel_o <= cand_sel_i;
      fresh_o      <= 1'b0;
    end
  end

endmodule

// File: rtl/hclk_wave.sv
module hclk_wave #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_i,
  input  logic             start_i,
  output logic             decide_o,
  output logic             level_o
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_w;
  logic             phase_done_w;
  logic             period_end_w;

  assign last_w       = half_i - CNT_W'(1);
  assign phase_done_w = (cnt_q == last_w);
  assign period_end_w = run_q && !level_o && phase_done_w;
  assign decide_o     = !run_q || period_end_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      level_o <= 1'b0;
      cnt_q   <= '0;
    end else if (decide_o) begin
      run_q   <= start_i;
      level_o <= start_i;
      cnt_q   <= '0;
    end else if (phase_done_w) begin
      level_o <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/hclk_div.sv
module hclk_div
  import hclk_div_pkg::*;
#(
  parameter int unsigned DIV_LO       = 256,
  parameter int unsigned DIV_MID      = 488,
  parameter int unsigned DIV_HI       = 976,
  parameter logic [2:0]  DEFAULT_SEL  = 3'd6,
  parameter logic [2:0]  DOZE_MIN_SEL = 3'd4
) (
  input  logic       ref2x_clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       doze_clk_en,
  input  logic [1:0] pwr_mode,
  output logic       host_clk
);

  localparam int unsigned MAX_A   = (DIV_LO > DIV_MID) ? DIV_LO : DIV_MID;
  localparam int unsigned MAX_DIV = (MAX_A > DIV_HI) ? MAX_A : DIV_HI;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);

  logic [2:0]       cand_sel;
  logic             cand_ok;
  logic [2:0]       active_sel;
  logic             fresh;
  logic             decide;
  logic             load;
  logic [CNT_W-1:0] half_act;

  assign load     = decide && cand_ok;
  assign half_act = CNT_W'(ratio_of(active_sel, DIV_LO, DIV_MID, DIV_HI));

  hclk_rate_pick #(
    .DEFAULT_SEL (DEFAULT_SEL),
    .DOZE_MIN_SEL(DOZE_MIN_SEL)
  ) u_pick (
    .fresh_i   (fresh),
    .rate_sel_i(rate_sel),
    .mode_i    (pwr_mode),
    .doze_en_i (doze_clk_en),
    .cand_sel_o(cand_sel),
    .cand_ok_o (cand_ok)
  );

  hclk_rate_reg #(
    .DEFAULT_SEL(DEFAULT_SEL)
  ) u_rate (
    .clk         (ref2x_clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .cand_sel_i  (cand_sel),
    .active_sel_o(active_sel),
    .fresh_o     (fresh)
  );

  hclk_wave #(
    .CNT_W(CNT_W)
  ) u_wave (
    .clk     (ref2x_clk),
    .rst_n   (rst_n),
    .half_i  (half_act),
    .start_i (load),
    .decide_o(decide),
    .level_o (host_clk)
  );

endmodule

// File: rtl/hclk_div_chk.sv
module hclk_div_chk
  import hclk_div_pkg::*;
#(
  parameter int unsigned DIV_LO       = 256,
  parameter int unsigned DIV_MID      = 488,
  parameter int unsigned DIV_HI       = 976,
  parameter logic [2:0]  DOZE_MIN_SEL = 3'd4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_clk,
  input logic [1:0] pwr_mode,
  input logic       doze_clk_en,
  input logic [2:0] active_sel,
  input logic       load
);

  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else        hi_len <= host_clk ? hi_len + 16'd1 : 16'd0;
  end

  // R3
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_clk) |-> hi_len == 16'(ratio_of(active_sel, DIV_LO, DIV_MID, DIV_HI)));

  // R4
  rate_moves_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_sel) |-> $past(load));

  // R6
  doze_start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_clk) && $past(pwr_mode) == 2'd1) |-> ($past(doze_clk_en) && active_sel >= DOZE_MIN_SEL));

  // R7
  no_start_when_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_clk) |-> ($past(pwr_mode) != 2'd2 && $past(pwr_mode) != 2'd3));

endmodule

bind hclk_div hclk_div_chk #(
  .DIV_LO      (DIV_LO),
  .DIV_MID     (DIV_MID),
  .DIV_HI      (DIV_HI),
  .DOZE_MIN_SEL(DOZE_MIN_SEL)
) u_chk (
  .clk        (ref2x_clk),
  .rst_n      (rst_n),
  .host_clk   (host_clk),
  .pwr_mode   (pwr_mode),
  .doze_clk_en(doze_clk_en),
  .active_sel (active_sel),
  .load       (load)
);

// File: tb/hclk_div_test.sv
module hclk_div_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       doze_en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       host_clk;

  always #4 clk = ~clk;

  hclk_div uut (
    .ref2x_clk  (clk),
    .rst_n      (rst_n),
    .rate_sel   (rate_sel),
    .doze_clk_en(doze_en),
    .pwr_mode   (mode),
    .host_clk   (host_clk)
  );

  int    checks = 0;
  int    errors = 0;
  string phase_req = "R1";
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;
  int    exp_tab [8] = '{1, 2, 4, 8, 16, 256, 488, 976};

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // behavioural reference: half-period in core cycles from the nominal frequency
  function automatic int ref_ratio(input int s);
    case (s)
      0: return 1;    1: return 2;    2: return 4;    3: return 8;
      4: return 16;   5: return 256;  6: return 488;  default: return 976;
    endcase
  endfunction

  function automatic bit ref_permit(input int m, input bit en, input int s);
    return (m == 0) || (m == 1 && en && s >= 4);
  endfunction

  bit m_run = 1'b0;
  bit m_fresh = 1'b1;
  int m_lvl = 0;
  int m_left = 0;
  int m_div = 0;
  int m_sel = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 1'b0; m_lvl = 0; m_fresh = 1'b1;
    end else if (!m_run || (m_lvl == 0 && m_left == 1)) begin
      m_sel = m_fresh ? 6 : int'(rate_sel);
      if (ref_permit(int'(mode), doze_en, m_sel)) begin
        m_run = 1'b1; m_lvl = 1; m_div = ref_ratio(m_sel); m_left = m_div; m_fresh = 1'b0;
      end else begin
        m_run = 1'b0; m_lvl = 0;
      end
    end else if (m_left == 1) begin
      m_lvl = 0; m_left = m_div;
    end else begin
      m_left--;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n)
      check(host_clk === m_lvl[0], phase_req, int'(host_clk), m_lvl, "per-cycle level");
  end

  task automatic measure(input int exp, input string req, input string what);
    int hi = 0;
    int lo = 0;
    int g = 0;
    while (host_clk === 1'b1 && g < 4000) begin @(negedge clk); g++; end
    while (host_clk !== 1'b1 && g < 8000) begin @(negedge clk); g++; end
    while (host_clk === 1'b1 && hi < 4000) begin @(negedge clk); hi++; end
    while (host_clk === 1'b0 && lo < 4000) begin @(negedge clk); lo++; end
    check(hi == exp, req, hi, exp, {what, " high phase"});
    check(lo == exp, "R3", lo, exp, {what, " low phase"});
  endtask

  task automatic expect_low(input int n, input string req, input string what);
    repeat (n) begin
      @(negedge clk);
      check(host_clk === 1'b0, req, int'(host_clk), 0, what);
    end
  endtask

  initial begin
    int hi;
    int lo;
    repeat (3) @(negedge clk);
    check(host_clk === 1'b0, "R1", int'(host_clk), 0, "output in reset");
    #1 rst_n = 1'b1;
    cmp_en = 1'b1;

    // R9: first period uses the default rate although rate_sel is 0
    phase_req = "R9";
    measure(488, "R9", "first period after reset");

    // R2 sweep through every code in Idle
    phase_req = "R2";
    for (int s = 0; s < 8; s++) begin
      rate_sel = 3'(s);
      measure(exp_tab[s], "R2", $sformatf("rate code %0d", s));
    end

    // R4: change rate in the middle of a long high phase
    phase_req = "R4";
    rate_sel = 3'd7;
    while (host_clk !== 1'b1) @(negedge clk);
    while (host_clk === 1'b1) @(negedge clk);
    while (host_clk !== 1'b1) @(negedge clk);
    hi = 0;
    while (host_clk === 1'b1 && hi < 4000) begin
      if (hi == 100) rate_sel = 3'd0;
      @(negedge clk); hi++;
    end
    lo = 0;
    while (host_clk === 1'b0 && lo < 4000) begin @(negedge clk); lo++; end
    check(hi == 976, "R4", hi, 976, "high phase after mid-period change");
    check(lo == 976, "R4", lo, 976, "low phase after mid-period change");
    measure(1, "R4", "new rate after change");

    // R6: Doze gating
    phase_req = "R6";
    mode = 2'd1; doze_en = 1'b0; rate_sel = 3'd4;
    repeat (6) @(negedge clk);
    expect_low(100, "R6", "doze without enable");
    doze_en = 1'b1;
    measure(16, "R6", "doze at 1 MHz");
    rate_sel = 3'd3;
    repeat (40) @(negedge clk);
    expect_low(100, "R6", "doze above 1 MHz");
    rate_sel = 3'd5;
    measure(256, "R6", "doze at 62.5 kHz");

    // R5: Idle ignores the doze enable
    phase_req = "R5";
    mode = 2'd0; doze_en = 1'b0; rate_sel = 3'd2;
    measure(4, "R5", "idle without enable");

    // R7: Hibernate and Off
    phase_req = "R7";
    mode = 2'd2; rate_sel = 3'd4;
    repeat (20) @(negedge clk);
    expect_low(200, "R7", "hibernate");
    mode = 2'd3;
    expect_low(100, "R7", "off");

    // R8: gate off mid-period, then restart
    phase_req = "R8";
    mode = 2'd0; rate_sel = 3'd7;
    while (host_clk !== 1'b1) @(negedge clk);
    while (host_clk === 1'b1) @(negedge clk);
    while (host_clk !== 1'b1) @(negedge clk);
    hi = 0;
    while (host_clk === 1'b1 && hi < 4000) begin
      if (hi == 50) mode = 2'd3;
      @(negedge clk); hi++;
    end
    check(hi == 976, "R8", hi, 976, "high phase completes after gate-off");
    expect_low(976, "R8", "low phase then held low");
    expect_low(300, "R8", "held low while gated");
    mode = 2'd0;
    @(negedge clk);
    check(host_clk === 1'b1, "R8", int'(host_clk), 1, "restart on next edge");
    measure(976, "R8", "full period after restart");

    // R1 and R9 again: reset during a run
    phase_req = "R9";
    rate_sel = 3'd0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check(host_clk === 1'b0, "R1", int'(host_clk), 0, "output cleared by reset");
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    measure(488, "R9", "first period after second reset");

    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finish_up();
    end
  end

endmodule